// File: doc/BRIEF.md
# Clock Output Enable and Mode Controller

This block is the control logic of a multi-output differential clock buffer. It has nineteen outputs, split into a group of fifteen and a group of four. For each output it decides whether the driver is on or held in high impedance. For each group it decides whether the group takes the 1:1 clock path or the geared path. It also produces the PLL power-down controls, the bandwidth selection and the fanout-bypass flag. Its inputs are:

- the active-low output-enable pins;
- a power-good pin, which is a power-down request while it is low;
- the strap pins;
- configuration register bits that a register file elsewhere drives.

The power-good pin is first passed through a two-flop synchronizer. Its rising edge captures the frequency-select strap and the bypass strap, then starts a release counter whose terminal count is programmable. No output drives until that counter expires. Each output is driven only when all of these hold: the block is out of power-down, the release counter has expired, the output's pin enable is low, and its register enable is high.

Top module: `clk_oe_ctl`

## Requirements
- R1: After reset the block is in this state: `drv_en` is all zero; both groups select the 1:1 path (`src_gear_a`=0, `src_gear_b`=0); `gear_pll_pd`=1; `base_pll_pd`=0; `fs4_init`=0; `bypass`=0 while `reg_byp_n`=1.
- R2: When `pwrgd` falls, `drv_en` becomes all zero at the third rising clock edge after the edge that first samples `pwrgd` low. Through the second such edge the outputs keep their previous value.
- R3: Count the first rising edge that samples `pwrgd` high as edge 0. With terminal count L on `dly_limit`, `drv_en` stays all zero through edge L+2 and may turn on at edge L+3. A value of L=0 is legal.
- R4: Output-enable pins are active low (1 = off). The pins map to outputs as follows: pin 0 controls outputs 0..4, pins 1..10 control outputs 5..14 one each, pin 11 controls outputs 15..16, and pin 12 controls outputs 17..18.
- R5: A register enable bit `reg_oe[i]`=0 keeps output i off whatever its pin says (1 = enabled). A pin or register change appears on `drv_en` one clock edge later.
- R6: `high_bw` is 1 when either `bw_pin_n` or `reg_bw_n` is 0.
- R7: `bypass` is 1 when either `reg_byp_n` is 0 or the bypass strap captured at the last power-good release was 0. A change of the strap while powered up has no effect. The captured strap resets to 1.
- R8: `fs4_init` is the inverse of the frequency-select strap captured at the last power-good release. A change of the strap at any other time has no effect. The captured strap resets to 1.
- R9: `src_gear_a` and `src_gear_b` follow `gear_en_a` and `gear_en_b` one edge later (1 = geared). `gear_pll_pd` is 1 when neither group is geared, and `base_pll_pd` is 1 when both groups are geared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd | input | 1 | Power-good pin; low requests power-down |
| oe_pin_n | input | 13 | Active-low output-enable pins |
| reg_oe | input | 19 | Register enables per output, 1 = enabled |
| gear_en_a | input | 1 | Gearing enable for the 15-output group |
| gear_en_b | input | 1 | Gearing enable for the 4-output group |
| bw_pin_n | input | 1 | Bandwidth pin, 0 = high bandwidth |
| reg_bw_n | input | 1 | Bandwidth register bit, 0 = high bandwidth |
| byp_strap_n | input | 1 | Bypass strap, 0 = fanout bypass, captured at release |
| reg_byp_n | input | 1 | Bypass register bit, 0 = fanout bypass |
| fsel_strap | input | 1 | Frequency-select strap, captured at release |
| dly_limit | input | 8 | Release counter terminal count |
| drv_en | output | 19 | Per-output driver enable |
| src_gear_a | output | 1 | 15-output group source, 1 = geared |
| src_gear_b | output | 1 | 4-output group source, 1 = geared |
| gear_pll_pd | output | 1 | Gear PLL power-down |
| base_pll_pd | output | 1 | 1:1 PLL power-down |
| high_bw | output | 1 | High PLL bandwidth selected |
| bypass | output | 1 | Fanout bypass mode selected |
| fs4_init | output | 1 | Initial value for the gear-select bit fs4 |

## Verification
The assertions check the following on every cycle:
- a synchronized power-down forces every driver off on the next edge;
- no driver is on unless the release counter had expired;
- a register enable of zero masks its output;
- the group source selects track the gear enables;
- the gear PLL is down whenever both groups use the 1:1 path;
- the high-bandwidth rule holds;
- the captured straps and `fs4_init` only move on a release edge.

Only the bench's scenarios can show the rest: the exact release latency for a given terminal count, including zero; the shared-pin grouping of each enable pin; the two-edge grace before power-down takes effect; and that strap changes after release leave `bypass` and `fs4_init` untouched.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;

  // Index of the active-low enable pin that controls output idx.
  // Outputs below n_lo share pin 0; outputs n_lo..n_a-1 own a pin each;
  // outputs from n_a upward share a pin per pair.
  function automatic int oe_pin_of(input int idx, input int n_lo, input int n_a);
    if (idx < n_lo)
      return 0;
    else if (idx < n_a)
      return idx - n_lo + 1;
    else
      return (n_a - n_lo + 1) + (idx - n_a) / 2;
  endfunction

  // Number of enable pins for a given output layout.
  function automatic int oe_pin_count(input int n_out, input int n_lo, input int n_a);
    return 1 + (n_a - n_lo) + (n_out - n_a + 1) / 2;
  endfunction

  // Wired-OR of two active-low mode controls: any zero selects the mode.
  function automatic logic low_wins(input logic a_n, input logic b_n);
    return ~(a_n & b_n);
  endfunction

endpackage

// File: rtl/clk_oe_pwrseq.sv
module clk_oe_pwrseq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd,
  input  logic             fsel_strap,
  input  logic             byp_strap_n,
  input  logic [DLY_W-1:0] dly_limit,
  output logic             pd_active,
  output logic             rise_evt,
  output logic             release_ready,
  output logic             fsel_lat,
  output logic             byp_lat
);

  logic             pg_s1, pg_s2, pg_d;
  logic             run_q;
  logic [DLY_W-1:0] cnt_q;
  logic             cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
      pg_d  <= 1'b0;
    end else begin
      pg_s1 <= pwrgd;
      pg_s2 <= pg_s1;
      pg_d  <= pg_s2;
    end
  end

  assign pd_active = ~pg_s2;
  assign rise_evt  = pg_s2 & ~pg_d;
  assign cnt_done  = (cnt_q >= dly_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_lat <= 1'b1;
      byp_lat  <= 1'b1;
    end else if (rise_evt) begin
      fsel_lat <= fsel_strap;
      byp_lat  <= byp_strap_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (pd_active) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_evt) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && !cnt_done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign release_ready = run_q & cnt_done & ~pd_active;

endmodule

// File: rtl/clk_oe_gate.sv
module clk_oe_gate #(
  parameter int N_OUT = 19,
  parameter int N_A   = 15,
  parameter int N_LO  = 5,
  parameter int N_PIN = clk_oe_pkg::oe_pin_count(N_OUT, N_LO, N_A)
) (
  input  logic [N_PIN-1:0] oe_pin_n,
  input  logic [N_OUT-1:0] reg_oe,
  input  logic             release_ready,
  output logic [N_OUT-1:0] en_next
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam int PIN = clk_oe_pkg::oe_pin_of(i, N_LO, N_A);
    assign en_next[i] = release_ready & ~oe_pin_n[PIN] & reg_oe[i];
  end

endmodule

// File: rtl/clk_oe_mode.sv
module clk_oe_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic gear_en_a,
  input  logic gear_en_b,
  input  logic bw_pin_n,
  input  logic reg_bw_n,
  input  logic byp_lat,
  input  logic reg_byp_n,
  input  logic fsel_lat,
  output logic src_gear_a,
  output logic src_gear_b,
  output logic gear_pll_pd,
  output logic base_pll_pd,
  output logic high_bw,
  output logic bypass,
  output logic fs4_init
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_gear_a <= 1'b0;
      src_gear_b <= 1'b0;
    end else begin
      src_gear_a <= gear_en_a;
      src_gear_b <= gear_en_b;
    end
  end

  assign gear_pll_pd = ~(src_gear_a | src_gear_b);
  assign base_pll_pd = src_gear_a & src_gear_b;
  assign high_bw     = clk_oe_pkg::low_wins(bw_pin_n, reg_bw_n);
  assign bypass      = clk_oe_pkg::low_wins(byp_lat, reg_byp_n);
  assign fs4_init    = ~fsel_lat;

endmodule

// File: rtl/clk_oe_ctl.sv
module clk_oe_ctl #(
  parameter  int N_OUT = 19,
  parameter  int N_A   = 15,
  parameter  int N_LO  = 5,
  parameter  int DLY_W = 8,
  localparam int N_PIN = clk_oe_pkg::oe_pin_count(N_OUT, N_LO, N_A)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd,
  input  logic [N_PIN-1:0] oe_pin_n,
  input  logic [N_OUT-1:0] reg_oe,
  input  logic             gear_en_a,
  input  logic             gear_en_b,
  input  logic             bw_pin_n,
  input  logic             reg_bw_n,
  input  logic             byp_strap_n,
  input  logic             reg_byp_n,
  input  logic             fsel_strap,
  input  logic [DLY_W-1:0] dly_limit,
  output logic [N_OUT-1:0] drv_en,
  output logic             src_gear_a,
  output logic             src_gear_b,
  output logic             gear_pll_pd,
  output logic             base_pll_pd,
  output logic             high_bw,
  output logic             bypass,
  output logic             fs4_init
);

  logic             pd_active;
  logic             rise_evt;
  logic             release_ready;
  logic             fsel_lat;
  logic             byp_lat;
  logic [N_OUT-1:0] en_next;

  clk_oe_pwrseq #(.DLY_W(DLY_W)) i_pwrseq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrgd         (pwrgd),
    .fsel_strap    (fsel_strap),
    .byp_strap_n   (byp_strap_n),
    .dly_limit     (dly_limit),
    .pd_active     (pd_active),
    .rise_evt      (rise_evt),
    .release_ready (release_ready),
    .fsel_lat      (fsel_lat),
    .byp_lat       (byp_lat)
  );

  clk_oe_gate #(.N_OUT(N_OUT), .N_A(N_A), .N_LO(N_LO), .N_PIN(N_PIN)) i_gate (
    .oe_pin_n      (oe_pin_n),
    .reg_oe        (reg_oe),
    .release_ready (release_ready),
    .en_next       (en_next)
  );

  clk_oe_mode i_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .gear_en_a   (gear_en_a),
    .gear_en_b   (gear_en_b),
    .bw_pin_n    (bw_pin_n),
    .reg_bw_n    (reg_bw_n),
    .byp_lat     (byp_lat),
    .reg_byp_n   (reg_byp_n),
    .fsel_lat    (fsel_lat),
    .src_gear_a  (src_gear_a),
    .src_gear_b  (src_gear_b),
    .gear_pll_pd (gear_pll_pd),
    .base_pll_pd (base_pll_pd),
    .high_bw     (high_bw),
    .bypass      (bypass),
    .fs4_init    (fs4_init)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_en <= '0;
    else        drv_en <= en_next;
  end

endmodule

// File: rtl/clk_oe_ctl_chk.sv
module clk_oe_ctl_chk #(
  parameter int N_OUT = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_active,
  input logic             rise_evt,
  input logic             release_ready,
  input logic             byp_lat,
  input logic [N_OUT-1:0] reg_oe,
  input logic [N_OUT-1:0] drv_en,
  input logic             gear_en_a,
  input logic             src_gear_a,
  input logic             src_gear_b,
  input logic             gear_pll_pd,
  input logic             bw_pin_n,
  input logic             reg_bw_n,
  input logic             high_bw,
  input logic             fs4_init
);

  // R2
  pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> (drv_en == '0));

  // R3
  rel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en != '0) |-> $past(release_ready));

  // R5
  reg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drv_en & ~$past(reg_oe)) == '0));

  // R9
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (src_gear_a == $past(gear_en_a)));

  // R9
  gear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_gear_a && !src_gear_b) |-> gear_pll_pd);

  // R6
  bw_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bw_pin_n || !reg_bw_n) |-> high_bw);

  // R8
  fs4_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(fs4_init));

  // R7
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(byp_lat));

endmodule

bind clk_oe_ctl clk_oe_ctl_chk #(.N_OUT(N_OUT)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pd_active     (pd_active),
  .rise_evt      (rise_evt),
  .release_ready (release_ready),
  .byp_lat       (byp_lat),
  .reg_oe        (reg_oe),
  .drv_en        (drv_en),
  .gear_en_a     (gear_en_a),
  .src_gear_a    (src_gear_a),
  .src_gear_b    (src_gear_b),
  .gear_pll_pd   (gear_pll_pd),
  .bw_pin_n      (bw_pin_n),
  .reg_bw_n      (reg_bw_n),
  .high_bw       (high_bw),
  .fs4_init      (fs4_init)
);

// File: tb/test_clk_oe_ctl.sv
module test_clk_oe_ctl;

  localparam int NO = 19;
  localparam int NP = 13;
  localparam logic [NO-1:0] ALL = 19'h7FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwrgd;
  logic [NP-1:0] oe_pin_n;
  logic [NO-1:0] reg_oe;
  logic          gear_en_a, gear_en_b, bw_pin_n, reg_bw_n;
  logic          byp_strap_n, reg_byp_n, fsel_strap;
  logic [7:0]    dly_limit;
  logic [NO-1:0] drv_en;
  logic          src_gear_a, src_gear_b, gear_pll_pd, base_pll_pd;
  logic          high_bw, bypass, fs4_init;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clk_oe_ctl i_clk_oe_ctl (
    .clk(clk), .rst_n(rst_n), .pwrgd(pwrgd), .oe_pin_n(oe_pin_n), .reg_oe(reg_oe),
    .gear_en_a(gear_en_a), .gear_en_b(gear_en_b), .bw_pin_n(bw_pin_n),
    .reg_bw_n(reg_bw_n), .byp_strap_n(byp_strap_n), .reg_byp_n(reg_byp_n),
    .fsel_strap(fsel_strap), .dly_limit(dly_limit), .drv_en(drv_en),
    .src_gear_a(src_gear_a), .src_gear_b(src_gear_b), .gear_pll_pd(gear_pll_pd),
    .base_pll_pd(base_pll_pd), .high_bw(high_bw), .bypass(bypass), .fs4_init(fs4_init)
  );

  // pin mask | register enables | expected drivers
  localparam logic [NP+2*NO-1:0] VEC [10] = '{
    {13'h0000, 19'h7FFFF, 19'h7FFFF},
    {13'h1FFF, 19'h7FFFF, 19'h00000},
    {13'h0001, 19'h7FFFF, 19'h7FFE0},
    {13'h1000, 19'h7FFFF, 19'h1FFFF},
    {13'h0800, 19'h7FFFF, 19'h67FFF},
    {13'h0002, 19'h7FFFF, 19'h7FFDF},
    {13'h0400, 19'h7FFFF, 19'h7BFFF},
    {13'h0000, 19'h55555, 19'h55555},
    {13'h0001, 19'h0001F, 19'h00000},
    {13'h1FFE, 19'h7FFFF, 19'h0001F}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pwrgd = 1'b0; oe_pin_n = '0; reg_oe = ALL;
    gear_en_a = 1'b0; gear_en_b = 1'b0; bw_pin_n = 1'b1; reg_bw_n = 1'b1;
    byp_strap_n = 1'b1; reg_byp_n = 1'b1; fsel_strap = 1'b1; dly_limit = 8'd0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 drv_en", 32'(drv_en), 32'h0);
    check("R1 src_gear_a", 32'(src_gear_a), 32'h0);
    check("R1 src_gear_b", 32'(src_gear_b), 32'h0);
    check("R1 gear_pll_pd", 32'(gear_pll_pd), 32'h1);
    check("R1 base_pll_pd", 32'(base_pll_pd), 32'h0);
    check("R1 fs4_init", 32'(fs4_init), 32'h0);
    check("R1 bypass", 32'(bypass), 32'h0);

    // R3 release with terminal count 5, straps captured (R7, R8)
    dly_limit = 8'd5; fsel_strap = 1'b0; byp_strap_n = 1'b0;
    pwrgd = 1'b1;
    step(8);
    check("R3 still off at L+2", 32'(drv_en), 32'h0);
    step(1);
    check("R3 on at L+3", 32'(drv_en), 32'(ALL));
    check("R8 fs4 captured", 32'(fs4_init), 32'h1);
    check("R7 bypass captured", 32'(bypass), 32'h1);

    // R7 R8 strap changes after release are ignored
    fsel_strap = 1'b1; byp_strap_n = 1'b1;
    step(2);
    check("R8 fs4 holds", 32'(fs4_init), 32'h1);
    check("R7 bypass holds", 32'(bypass), 32'h1);

    // R4 R5 pin grouping and register masking table
    for (int k = 0; k < 10; k++) begin
      oe_pin_n = VEC[k][2*NO +: NP];
      reg_oe   = VEC[k][NO +: NO];
      step(1);
      check(k < 7 ? "R4 pin map" : "R5 reg mask", 32'(drv_en), 32'(VEC[k][0 +: NO]));
    end
    oe_pin_n = '0; reg_oe = ALL;
    step(1);

    // R2 power-down with two-edge grace
    pwrgd = 1'b0;
    step(2);
    check("R2 grace", 32'(drv_en), 32'(ALL));
    step(1);
    check("R2 off", 32'(drv_en), 32'h0);
    check("R8 fs4 during pd", 32'(fs4_init), 32'h1);

    // R3 terminal count zero; new strap values captured
    dly_limit = 8'd0;
    pwrgd = 1'b1;
    step(3);
    check("R3 L0 off", 32'(drv_en), 32'h0);
    step(1);
    check("R3 L0 on", 32'(drv_en), 32'(ALL));
    check("R7 bypass recaptured", 32'(bypass), 32'h0);
    check("R8 fs4 recaptured", 32'(fs4_init), 32'h0);
    reg_byp_n = 1'b0;
    step(1);
    check("R7 reg bypass", 32'(bypass), 32'h1);
    reg_byp_n = 1'b1;

    // R6 bandwidth wired-OR
    bw_pin_n = 1'b0; step(1);
    check("R6 pin low", 32'(high_bw), 32'h1);
    bw_pin_n = 1'b1; reg_bw_n = 1'b0; step(1);
    check("R6 reg low", 32'(high_bw), 32'h1);
    reg_bw_n = 1'b1; step(1);
    check("R6 both high", 32'(high_bw), 32'h0);

    // R9 group sources and PLL power-down
    gear_en_a = 1'b1; step(1);
    check("R9 src a", 32'(src_gear_a), 32'h1);
    check("R9 src b", 32'(src_gear_b), 32'h0);
    check("R9 gear pll up", 32'(gear_pll_pd), 32'h0);
    check("R9 base pll up", 32'(base_pll_pd), 32'h0);
    gear_en_b = 1'b1; step(1);
    check("R9 base pll down", 32'(base_pll_pd), 32'h1);
    gear_en_a = 1'b0; gear_en_b = 1'b0; step(1);
    check("R9 gear pll down", 32'(gear_pll_pd), 32'h1);
    check("R9 base pll back", 32'(base_pll_pd), 32'h0);

    finish_run();
  end

endmodule